// File: doc/BRIEF.md
# Three-Channel Residue Adder

This block adds two unsigned binary operands by moving them into a residue number system built on the pairwise coprime moduli 3, 5 and 7, whose product gives a dynamic range of exactly 105 values (0 to 104). Each operand is first reduced into its three residues. Three modular adders, one for each modulus, then work side by side. No carry passes from one channel to another. The residue result is mapped back to an ordinary binary number through Chinese remainder weighting.

A caller presents both operands with a valid strobe. One clock later the block raises a one-cycle done flag. Alongside it the block shows the three result residues and the reconstructed binary sum, which equals the true sum modulo 105. Callers must keep the true sum in range, because the block has no sign, compare or overflow logic. Any operand outside the range 0 to 104 is reported as a bad operand.

Top module: `rns_adder`

## Requirements
- R1: `done` is high in the cycle after a clock edge at which `in_valid` was sampled high, and low after any edge at which `in_valid` was low.
- R2: While `rst_n` is low and after its release, before any valid input, `done`, `bad_operand`, all residue outputs and `sum_out` are zero.
- R3: For operands both below 105, `res_m3`, `res_m5` and `res_m7` equal (a+b) mod 3, (a+b) mod 5 and (a+b) mod 7, and each is below its modulus.
- R4: For operands both below 105, `sum_out` equals (a+b) mod 105.
- R5: Reconstruction follows the Chinese remainder mapping. Operands 5 and 6 produce residues (2,1,4), which give `sum_out` 11. Operands 33 and 49 produce residues (1,2,5), which give 82.
- R6: While `in_valid` is low, the residue outputs, `sum_out` and `bad_operand` keep their values.
- R7: If either operand is 105 or more, `bad_operand` is high together with `done`, and all residue outputs and `sum_out` are zero. Otherwise `bad_operand` is low with `done`.
- R8: Whenever `done` is high, `sum_out` is below 105.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 7 | First unsigned operand |
| op_b | input | 7 | Second unsigned operand |
| done | output | 1 | Result registered from the previous valid input |
| bad_operand | output | 1 | An operand was outside 0..104 |
| res_m3 | output | 2 | Result residue modulo 3 |
| res_m5 | output | 3 | Result residue modulo 5 |
| res_m7 | output | 3 | Result residue modulo 7 |
| sum_out | output | 7 | Reconstructed binary sum modulo 105 |

## Verification
A fault in one channel's converter or adder shows up one cycle after the strobe. The wrong residue appears on its port, and because the reconstruction depends on every channel, the same fault also moves `sum_out`, usually by a multiple of the other two moduli. A wrong reconstruction weight leaves the residues correct but breaks `sum_out` for every result where that channel's residue is nonzero. For that reason both sets of outputs are compared for all 11025 in-range operand pairs. Stale or corrupted held state is visible as soon as the strobe drops, so the outputs are also watched across idle cycles and after rejected operands.

// File: rtl/rns_pkg.sv
package rns_pkg;

    // Remainder of x by m through binary long division with restoring steps
    function automatic int mod_reduce(input int x, input int m);
        int r;
        r = x;
        for (int k = 12; k >= 0; k--) begin
            if (r >= (m << k)) r = r - (m << k);
        end
        return r;
    endfunction

    // Weight that is 1 modulo mi and 0 modulo every other channel modulus
    function automatic int crt_weight(input int mi, input int prod);
        int base;
        int w;
        base = prod / mi;
        w = 0;
        for (int k = 1; k < mi; k++) begin
            if (((base * k) % mi) == 1) w = base * k;
        end
        return w;
    endfunction

endpackage

// File: rtl/rns_to_residue.sv
module rns_to_residue #(
    parameter int MOD = 3,
    parameter int IW  = 7,
    parameter int RW  = 3
) (
    input  logic [IW-1:0] bin_in,
    output logic [RW-1:0] res_out
);
    import rns_pkg::*;

    always_comb begin
        res_out = RW'(mod_reduce(int'(bin_in), MOD));
    end
endmodule

// File: rtl/rns_mod_add.sv
module rns_mod_add #(
    parameter int MOD = 3,
    parameter int RW  = 3
) (
    input  logic [RW-1:0] add_a,
    input  logic [RW-1:0] add_b,
    output logic [RW-1:0] add_s
);
    localparam logic [RW:0] MODV = (RW+1)'(MOD);

    logic [RW:0] raw;

    always_comb begin
        raw = {1'b0, add_a} + {1'b0, add_b};
        if (raw >= MODV) add_s = RW'(raw - MODV);
        else             add_s = RW'(raw);
    end
endmodule

// File: rtl/rns_crt.sv
module rns_crt #(
    parameter int M0 = 3,
    parameter int M1 = 5,
    parameter int M2 = 7,
    parameter int RW = 3,
    parameter int OW = 7
) (
    input  logic [RW-1:0] r0,
    input  logic [RW-1:0] r1,
    input  logic [RW-1:0] r2,
    output logic [OW-1:0] value
);
    import rns_pkg::*;

    localparam int PROD = M0 * M1 * M2;
    localparam int W0   = crt_weight(M0, PROD);
    localparam int W1   = crt_weight(M1, PROD);
    localparam int W2   = crt_weight(M2, PROD);

    int acc;

    always_comb begin
        acc   = W0 * int'(r0) + W1 * int'(r1) + W2 * int'(r2);
        value = OW'(mod_reduce(acc, PROD));
    end
endmodule

// File: rtl/rns_adder.sv
module rns_adder #(
    parameter int M0  = 3,
    parameter int M1  = 5,
    parameter int M2  = 7,
    parameter int OPW = 7,
    parameter int R0W = $clog2(M0),
    parameter int R1W = $clog2(M1),
    parameter int R2W = $clog2(M2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic           done,
    output logic           bad_operand,
    output logic [R0W-1:0] res_m3,
    output logic [R1W-1:0] res_m5,
    output logic [R2W-1:0] res_m7,
    output logic [OPW-1:0] sum_out
);
    localparam int NCH  = 3;
    localparam int PROD = M0 * M1 * M2;
    localparam int RW   = (R0W > R1W) ? ((R0W > R2W) ? R0W : R2W)
                                      : ((R1W > R2W) ? R1W : R2W);
    localparam int MODS [NCH] = '{M0, M1, M2};
    localparam logic [OPW-1:0] LIMIT = OPW'(PROD);

    typedef struct packed {
        logic                    done;
        logic                    bad;
        logic [NCH-1:0][RW-1:0]  res;
        logic [OPW-1:0]          sum;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0][RW-1:0] ra, rb, rs;
    logic [OPW-1:0]         recon;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        rns_to_residue #(.MOD(MODS[ch]), .IW(OPW), .RW(RW)) i_cva (
            .bin_in (op_a),
            .res_out(ra[ch])
        );
        rns_to_residue #(.MOD(MODS[ch]), .IW(OPW), .RW(RW)) i_cvb (
            .bin_in (op_b),
            .res_out(rb[ch])
        );
        rns_mod_add #(.MOD(MODS[ch]), .RW(RW)) i_add (
            .add_a(ra[ch]),
            .add_b(rb[ch]),
            .add_s(rs[ch])
        );
    end

    rns_crt #(.M0(M0), .M1(M1), .M2(M2), .RW(RW), .OW(OPW)) i_crt (
        .r0   (rs[0]),
        .r1   (rs[1]),
        .r2   (rs[2]),
        .value(recon)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            if ((op_a >= LIMIT) || (op_b >= LIMIT)) begin
                st_d.bad = 1'b1;
                st_d.res = '0;
                st_d.sum = '0;
            end else begin
                st_d.bad = 1'b0;
                st_d.res = rs;
                st_d.sum = recon;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done        = st_q.done;
    assign bad_operand = st_q.bad;
    assign res_m3      = st_q.res[0][R0W-1:0];
    assign res_m5      = st_q.res[1][R1W-1:0];
    assign res_m7      = st_q.res[2][R2W-1:0];
    assign sum_out     = st_q.sum;

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done); // R1
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done); // R1
    AST_RES_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(res_m3) < M0 && int'(res_m5) < M1 && int'(res_m7) < M2)); // R3
    AST_SUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(sum_out) < PROD)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_out) && $stable(res_m7) && $stable(bad_operand))); // R6
    AST_BAD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bad_operand) |-> (sum_out == '0 && res_m3 == '0 && res_m5 == '0)); // R7
endmodule

// File: tb/test_rns_adder.sv
module test_rns_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [6:0] op_a = '0;
    logic [6:0] op_b = '0;
    logic       done, bad_operand;
    logic [1:0] res_m3;
    logic [2:0] res_m5, res_m7;
    logic [6:0] sum_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rns_adder i_rns_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .done(done), .bad_operand(bad_operand),
        .res_m3(res_m3), .res_m5(res_m5), .res_m7(res_m7), .sum_out(sum_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one pair for one cycle, sample at the following falling edge
    task automatic apply(input int a, input int b);
        @(negedge clk);
        op_a = 7'(a); op_b = 7'(b); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_pair(input int a, input int b, input string tag);
        int s;
        s = a + b;
        apply(a, b);
        check({tag, " R1 done"}, int'(done), 1);
        check({tag, " R7 bad low"}, int'(bad_operand), 0);
        check({tag, " R3 mod3"}, int'(res_m3), s % 3);
        check({tag, " R3 mod5"}, int'(res_m5), s % 5);
        check({tag, " R3 mod7"}, int'(res_m7), s % 7);
        check({tag, " R4 sum"}, int'(sum_out), s % 105);
    endtask

    task automatic check_bad(input int a, input int b);
        apply(a, b);
        check("R7 bad flag", int'(bad_operand), 1);
        check("R7 sum zero", int'(sum_out), 0);
        check("R7 residues zero", int'(res_m3) + int'(res_m5) + int'(res_m7), 0);
        check("R8 done with bad", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2 done in reset", int'(done), 0);
        check("R2 sum in reset", int'(sum_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 done after reset", int'(done), 0);
        check("R2 bad after reset", int'(bad_operand), 0);
        check("R2 residues after reset", int'(res_m3) + int'(res_m5) + int'(res_m7), 0);
        check("R2 sum after reset", int'(sum_out), 0);

        check_pair(5, 6, "R5 eleven");
        check("R5 eleven residues", int'(res_m3) * 100 + int'(res_m5) * 10 + int'(res_m7), 214);
        check_pair(33, 49, "R5 eighty-two");
        check("R5 eighty-two residues", int'(res_m3) * 100 + int'(res_m5) * 10 + int'(res_m7), 125);

        // R6: idle cycles keep the last result, done drops (R1)
        @(negedge clk);
        check("R1 done low when idle", int'(done), 0);
        check("R6 sum held", int'(sum_out), 82);
        op_a = 7'd1; op_b = 7'd1;
        @(negedge clk);
        check("R6 sum held with new idle inputs", int'(sum_out), 82);
        check("R6 mod7 held", int'(res_m7), 5);

        // R4 R8 wrap boundaries
        check_pair(104, 104, "R8 max");
        check_pair(104, 1, "R4 wrap");
        check_pair(0, 0, "R4 zero");

        // R7 out-of-range operands
        check_bad(105, 0);
        check_bad(0, 127);
        check_bad(127, 127);
        @(negedge clk);
        check("R6 bad held", int'(bad_operand), 1);
        check_pair(1, 2, "R7 recovery");

        // Exhaustive sweep of every in-range pair, back to back
        for (int a = 0; a < 105; a++) begin
            for (int b = 0; b < 105; b++) begin
                check_pair(a, b, "sweep");
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule